// File: doc/BRIEF.md
# Per-Port Interrupt Status Controller

This block gathers 32 interrupt sources belonging to one root port into a single summary interrupt line. Sources 0 to 3 are the four legacy level-sensitive lines. Each one is seen live in the status view and is never stored. Every other source is an event. The block stores it on a rising edge and holds it until software writes a one to its status bit. A per-source mask decides which status bits may drive the summary line. The mask changes only through two dedicated write ports: one sets mask bits and the other clears them. A masked event is still recorded in status.

Software uses a small register port to reach the block. The port has a write strobe, a 2-bit word select and 32-bit write data. Read data is a combinational view of the selected word. The fixed event positions are named in the package: port error 4, the error-reporting group 4 to 7, bandwidth management 11, link-up 12, link-down 14, MSI error 18, requester-ID mapping error 22 and completion timeout 23. The logic treats all of these positions in the same way.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every stored status bit reads 0 and `irq_o` is low.
- R2: For bits 4 to 31, a 0-to-1 change of `src_i` between two consecutive clocks sets the status bit. The bit stays set after the source falls. A source held high does not set it again.
- R3: Status bits 0 to 3 read back the current value of `src_i[3:0]` in the same cycle. They are never stored.
- R4: A write to word 0 (status) clears every bit from 4 to 31 whose write-data bit is 1. Bits written as 0 keep their value. The write has no effect on bits 0 to 3.
- R5: If a rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to word 2 sets the mask bits whose write-data bit is 1. A write to word 3 clears them. A write to word 1 is ignored. No other write changes the mask.
- R7: Word 1 reads the mask. Words 2 and 3 read as zero.
- R8: `irq_o` is high exactly when some bit of the status view (stored bits 4 to 31 and live bits 0 to 3) is 1 and its mask bit is 0.
- R9: An event on a masked source is still stored in status, and it raises `irq_o` once it is unmasked.
- R10: A source that is already high while reset is released is not taken as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| src_i | input | 32 | Interrupt sources; bits 0 to 3 level, the rest event |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_addr_i | input | 2 | Word select: 0 status, 1 mask, 2 mask-set, 3 mask-clear |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| irq_o | output | 1 | Summary interrupt |

## Verification
The hardest case to produce is a clearing write that lands in the same cycle as a new rising edge on the same bit. Reaching it needs a source that has just been low, and the write has to be placed in exactly the cycle in which that source goes high. The stimulus first drops the source for one step and then raises it together with the write. A second awkward case is a source that is high across the release of reset. The bench asserts reset in the middle of the run with a source held high, and afterwards it reads status both before and after a real edge.

// File: rtl/port_irq_pkg.sv
`timescale 1ns/1ps
package port_irq_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_MSET   = 2'd2,
    SEL_MCLR   = 2'd3
  } reg_sel_e;

  // Fixed event positions in the 32-bit source vector
  localparam int unsigned EVT_PORT_ERR    = 4;
  localparam int unsigned EVT_ERR_GRP_LO  = 4;
  localparam int unsigned EVT_ERR_GRP_HI  = 7;
  localparam int unsigned EVT_BW_MGMT     = 11;
  localparam int unsigned EVT_LINK_UP     = 12;
  localparam int unsigned EVT_LINK_DOWN   = 14;
  localparam int unsigned EVT_MSI_ERR     = 18;
  localparam int unsigned EVT_RID_MAP_ERR = 22;
  localparam int unsigned EVT_CPL_TIMEOUT = 23;

endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] stat_o
);

  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] stat_q, stat_d;
  logic [WIDTH-1:0] rise;
  logic             prev_en, stat_en;

  // A new edge wins over a clear in the same cycle
  always_comb begin
    rise    = src_i & ~prev_q;
    prev_d  = src_i;
    prev_en = |(src_i ^ prev_q);
    stat_d  = (stat_q & ~clr_i) | rise;
    stat_en = (|rise) | (|(clr_i & stat_q));
  end

  // prev resets to ones: a source high at reset release is no event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      stat_q <= '0;
    end else begin
      if (prev_en) prev_q <= prev_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q, mask_d;
  logic             mask_en;

  always_comb begin
    mask_d  = (mask_q | set_i) & ~clr_i;
    mask_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
module irq_reg_port
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4,
  localparam int unsigned EDGE_N   = NUM_SRC - NUM_LEVEL
) (
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0]    wdata_i,
  input  logic [NUM_SRC-1:0]    view_i,
  input  logic [NUM_SRC-1:0]    mask_i,
  output logic [EDGE_N-1:0]     stat_clr_o,
  output logic [NUM_SRC-1:0]    mset_o,
  output logic [NUM_SRC-1:0]    mclr_o,
  output logic [NUM_SRC-1:0]    rdata_o
);

  reg_sel_e sel;

  always_comb begin
    sel        = reg_sel_e'(addr_i);
    stat_clr_o = '0;
    mset_o     = '0;
    mclr_o     = '0;
    rdata_o    = '0;
    case (sel)
      SEL_STATUS: begin
        rdata_o = view_i;
        if (wr_i) stat_clr_o = wdata_i[NUM_SRC-1:NUM_LEVEL];
      end
      SEL_MASK: rdata_o = mask_i;
      SEL_MSET: if (wr_i) mset_o = wdata_i;
      SEL_MCLR: if (wr_i) mclr_o = wdata_i;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/port_irq_ctrl.sv
`timescale 1ns/1ps
module port_irq_ctrl
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4,
  localparam int unsigned EDGE_N   = NUM_SRC - NUM_LEVEL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_SRC-1:0]    reg_wdata_i,
  output logic [NUM_SRC-1:0]    reg_rdata_o,
  output logic                  irq_o
);

  logic [1:0]         rst_pipe;
  logic               rst_n_sync;
  logic [EDGE_N-1:0]  edge_stat;
  logic [EDGE_N-1:0]  stat_clr;
  logic [NUM_SRC-1:0] stat_view;
  logic [NUM_SRC-1:0] mask_vec;
  logic [NUM_SRC-1:0] mask_set;
  logic [NUM_SRC-1:0] mask_clr;

  // Assert asynchronously, release after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  irq_edge_latch #(.WIDTH(EDGE_N)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .src_i  (src_i[NUM_SRC-1:NUM_LEVEL]),
    .clr_i  (stat_clr),
    .stat_o (edge_stat)
  );

  irq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (mask_set),
    .clr_i  (mask_clr),
    .mask_o (mask_vec)
  );

  generate
    if (NUM_LEVEL > 0) begin : g_level
      assign stat_view = {edge_stat, src_i[NUM_LEVEL-1:0]};
    end else begin : g_no_level
      assign stat_view = edge_stat;
    end
  endgenerate

  irq_reg_port #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_regs (
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .view_i     (stat_view),
    .mask_i     (mask_vec),
    .stat_clr_o (stat_clr),
    .mset_o     (mask_set),
    .mclr_o     (mask_clr),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_o = |(stat_view & ~mask_vec);

endmodule

// File: rtl/port_irq_ctrl_chk.sv
`timescale 1ns/1ps
module port_irq_ctrl_chk
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4,
  localparam int unsigned EDGE_N   = NUM_SRC - NUM_LEVEL
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_SRC-1:0]    src_i,
  input logic                  reg_wr_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [NUM_SRC-1:0]    reg_wdata_i,
  input logic                  irq_o,
  input logic [EDGE_N-1:0]     edge_stat,
  input logic [NUM_SRC-1:0]    mask_vec
);

  logic [EDGE_N-1:0] src_q;
  logic [EDGE_N-1:0] rise;
  logic [EDGE_N-1:0] clr_e;
  logic              mwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '1;
    else        src_q <= src_i[NUM_SRC-1:NUM_LEVEL];
  end

  always_comb begin
    rise  = src_i[NUM_SRC-1:NUM_LEVEL] & ~src_q;
    clr_e = (reg_wr_i && reg_addr_i == SEL_STATUS) ? reg_wdata_i[NUM_SRC-1:NUM_LEVEL] : '0;
    mwr   = reg_wr_i && (reg_addr_i == SEL_MSET || reg_addr_i == SEL_MCLR);
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((edge_stat & $past(rise)) == $past(rise))); // R2
  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|rise) && !(|clr_e)) |=> $stable(edge_stat)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_e & ~rise)) |=> ((edge_stat & $past(clr_e & ~rise)) == '0)); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_e & rise)) |=> ((edge_stat & $past(clr_e & rise)) == $past(clr_e & rise))); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == SEL_MSET) |=> ((mask_vec & $past(reg_wdata_i)) == $past(reg_wdata_i))); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == SEL_MCLR) |=> ((mask_vec & $past(reg_wdata_i)) == '0)); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mwr |=> $stable(mask_vec)); // R6
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_vec) |-> !irq_o); // R8
  AST_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i[NUM_LEVEL-1:0] & ~mask_vec[NUM_LEVEL-1:0])) |-> irq_o); // R3

endmodule

bind port_irq_ctrl port_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .src_i       (src_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .edge_stat   (edge_stat),
  .mask_vec    (mask_vec)
);

// File: tb/port_irq_ctrl_bench.sv
`timescale 1ns/1ps
module port_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        reg_wr_i;
  logic [1:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  always #5 clk = ~clk;

  port_irq_ctrl u_port_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0;
  int          bad   = 0;
  logic [31:0] m_stat, m_mask, m_prev;

  localparam logic [31:0] LVL = 32'h0000_000F;

  task automatic apply_reset(input logic [31:0] src);
    @(negedge clk); #2;
    rst_n = 1'b0; src_i = src; reg_wr_i = 1'b0; reg_addr_i = 2'd0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_stat = '0; m_mask = '1; m_prev = src;
  endtask

  // Driver: apply one cycle of stimulus, then queue what the next sample must show
  task automatic step(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                      input logic [31:0] src, input string tag);
    logic [31:0] rise, clr, view;
    exp_t e;
    @(negedge clk); #2;
    reg_wr_i = wr; reg_addr_i = addr; reg_wdata_i = wd; src_i = src;
    @(posedge clk); #1;
    rise   = src & ~m_prev & ~LVL;
    clr    = (wr && addr == 2'd0) ? (wd & ~LVL) : '0;
    m_stat = (m_stat & ~clr) | rise;
    m_prev = src;
    if (wr && addr == 2'd2) m_mask = m_mask | wd;
    if (wr && addr == 2'd3) m_mask = m_mask & ~wd;
    view  = m_stat | (src & LVL);
    e.rd  = (addr == 2'd0) ? view : (addr == 2'd1) ? m_mask : '0;
    e.irq = |(view & ~m_mask);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total += 2;
        if (reg_rdata_o !== e.rd) begin
          bad++;
          $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata_o, e.rd);
        end
        if (irq_o !== e.irq) begin
          bad++;
          $display("FAIL %s irq actual=%b expected=%b", e.tag, irq_o, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    apply_reset('0);
    step(0, 2'd1, '0, '0, "R1");                          // mask all ones
    step(0, 2'd0, '0, '0, "R1");                          // status clear
    step(0, 2'd0, '0, 32'h0000_1000, "R9");               // link-up latched while masked
    step(0, 2'd0, '0, '0, "R2");                          // held after source falls
    step(0, 2'd0, '0, 32'h0000_0005, "R3");               // level bits live
    step(0, 2'd0, '0, '0, "R3");                          // level bits not stored
    step(0, 2'd0, '0, 32'h0080_4000, "R2");               // bits 23 and 14
    step(0, 2'd0, '0, 32'h0080_4000, "R2");               // held high: no retrigger
    step(1, 2'd0, 32'h0000_4002, 32'h0080_0002, "R4");    // clear 14, bit 1 untouched
    step(0, 2'd0, '0, '0, "R4");
    step(1, 2'd0, 32'h0080_0000, 32'h0080_0000, "R5");    // edge and clear together
    step(1, 2'd3, 32'h0000_1000, 32'h0080_0000, "R7");    // unmask 12, word 3 reads 0
    step(0, 2'd1, '0, 32'h0080_0000, "R6");
    step(1, 2'd1, '0, 32'h0080_0000, "R6");               // write to mask word ignored
    step(1, 2'd2, 32'h0000_1000, 32'h0080_0000, "R7");    // mask 12 again, word 2 reads 0
    step(0, 2'd1, '0, '0, "R8");
    step(1, 2'd3, 32'h0000_0001, '0, "R8");               // unmask level bit 0
    step(0, 2'd0, '0, 32'h0000_0001, "R3");
    step(0, 2'd0, '0, '0, "R8");
    step(1, 2'd0, 32'hFFFF_FFFF, 32'h0000_000F, "R4");    // clear all edges, levels stay
    apply_reset(32'h0010_0000);
    step(0, 2'd0, '0, 32'h0010_0000, "R10");
    step(0, 2'd1, '0, 32'h0010_0000, "R1");
    step(0, 2'd0, '0, '0, "R10");
    step(0, 2'd0, '0, 32'h0010_0000, "R2");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule